// File: doc/BRIEF.md
# Switch-and-Button Operand Entry Controller

This controller is the front end of a four-digit financial calculator. It uses ten slide switches as raw data and four push buttons as commands to walk the user through four phases. The user first picks a calculation mode, then types in the operands that mode needs, then launches the selected compute engine, and finally views its result. The controller holds the four operand registers and drives them straight to the engines: two 27-bit money values (future and present), a 7-bit rate and a 6-bit year count. It also drives a 2-bit mode select, one start line per engine, a start line for an external binary-to-display converter, and four 7-bit symbol codes for downstream seven-segment decoders.

Every step forward needs button 3 plus a switch reserved for the current step, so a stray button press cannot move the sequence on. Input steps that the selected mode does not use are passed through in one cycle each. After every operand load the controller shows the entered value for a fixed number of cycles and then returns to the same input step. An external range checker drives an error flag. While that flag is high in an input step, the controller passes the externally supplied digit codes, which carry a flashing error pattern, through in place of its prompt. The data interfaces here are plain register outputs and have no stream handshake. The engines read the operand buses whenever they need them, so there is no back-pressure.

Top module: `calc_entry_ctrl`

## Requirements
- R1: Holding buttons 3:0 all pressed with switch 9 off resets the block at once, with no clock edge needed. The reset clears the future and present values to 0, sets the rate and year count to 1, sets the mode to 2'b11 and raises sys_rst. After the buttons are released, the block enters the ready step on the next clock edge and sys_rst falls.
- R2: In the ready step the display shows symbol codes 22, 0, 13, 14 from left to right. Button 0 copies switches 1:0 into mode_out. Mode 2'b00 selects the rate engine, 2'b01 the future-value engine and 2'b10 the doubling-time engine.
- R3: led_mode[0], led_mode[1] and led_mode[2] light for modes 2'b00, 2'b01 and 2'b10 respectively. Mode 2'b11 lights none of them.
- R4: Each step advances only when button 3 is pressed with its own switch held on: switch 9 in the ready step, then switches 8, 7, 6 and 5 in the future-value, present-value, rate and year steps. Button 3 with any other switch has no effect.
- R5: The input steps run in the order future value, present value, rate, years, then launch. The future-value step is used only in mode 00. The present-value and year steps are used in modes 00 and 01. The rate step is used in modes 01 and 10. An unused step lasts exactly one cycle and ignores all buttons.
- R6: In a money step, button 0 writes switches 9:0 into bits 9:0, button 1 writes switches 9:0 into bits 19:10, and button 2 writes switches 6:0 into bits 26:20. Button 0 wins over button 1, which wins over button 2. In the rate and year steps, only button 0 loads (switches 6:0 and 5:0 respectively), and buttons 1 and 2 are ignored. A load takes priority over an advance in the same cycle.
- R7: A load moves to an echo step that lasts exactly ECHO_CYCLES cycles and then returns to the same input step. In a money echo, conv_start is low during the first echo cycle only. At all other times conv_start is high.
- R8: A money echo shows dig_in. A rate echo shows 1, 22, 36, rate. A year echo shows 34, 29, 36, and the year count with a zero added on top.
- R9: With err_in low, the input steps show their prompts: 8,37,15,30 for future value; 7,37,25,30 for present value; 6,37,1,22 for rate; 5,37,34,29 for years. With err_in high, the display shows dig_in instead.
- R10: The first launch cycle drives low only the start line of the engine that mode selects. The second launch cycle drives all start lines high. Mode 11 at launch drives no start line low and returns to the ready step.
- R11: After launch the block shows dig_in and holds led_done high, ignoring all buttons, until the next reset. All start lines rest high outside the first launch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sw | input | 10 | Slide switches, data and step-advance qualifiers |
| key | input | 4 | Push buttons, 1 = pressed |
| err_in | input | 1 | Operand out of range, from the external checker |
| dig_in | input | 28 | Four external symbol codes, leftmost digit in bits 6:0 |
| disp_out | output | 28 | Four symbol codes to the decoders, leftmost digit in bits 6:0 |
| fv_out | output | 27 | Future value operand |
| pv_out | output | 27 | Present value operand |
| rate_out | output | 7 | Rate operand |
| years_out | output | 6 | Year-count operand |
| mode_out | output | 2 | Selected calculation mode |
| start_rate | output | 1 | Rate engine start, low pulse launches |
| start_fv | output | 1 | Future-value engine start, low pulse launches |
| start_dt | output | 1 | Doubling-time engine start, low pulse launches |
| conv_start | output | 1 | Display converter start, low pulse during a money echo |
| sys_rst | output | 1 | Global reset to the rest of the calculator |
| led_mode | output | 3 | One indicator per defined mode |
| led_done | output | 1 | Result-ready indicator |

## Verification
The bench runs the whole sequence once in each of the four mode codes. Comparing which prompts appear, and how many cycles pass between them, separates correct skipping from a wrong kept-step table. The rate and year steps are swept over every switch value, which shows whether the load slice and the echo symbols match the operand bit for bit. The money steps use three slices with distinct bit patterns and a two-button press, so a swapped slice, a shifted field or a wrong button priority each give a different value. In every kept step the bench also tries a wrong advance switch, ignored buttons and a raised error flag, and it counts echo cycles exactly to catch a timer that is off by one.

// File: rtl/calc_entry_pkg.sv
package calc_entry_pkg;

  localparam int SYM_W  = 7;
  localparam int NDIG   = 4;
  localparam int DISP_W = SYM_W * NDIG;
  localparam int OPND_W = 27;
  localparam int RATE_W = 7;
  localparam int YRS_W  = 6;
  localparam int SW_W   = 10;

  localparam logic [1:0] MODE_RATE = 2'b00;
  localparam logic [1:0] MODE_FV   = 2'b01;
  localparam logic [1:0] MODE_DT   = 2'b10;
  localparam logic [1:0] MODE_NONE = 2'b11;

  localparam logic [SYM_W-1:0] SYM_DASH = 7'd37;
  localparam logic [SYM_W-1:0] SYM_EQ   = 7'd36;

  typedef enum logic [3:0] {
    ST_RST, ST_READY,
    ST_IN_FV, ST_IN_PV, ST_IN_RATE, ST_IN_YRS,
    ST_ECHO_FV, ST_ECHO_PV, ST_ECHO_RATE, ST_ECHO_YRS,
    ST_LAUNCH0, ST_LAUNCH1, ST_RESULT
  } ctl_state_e;

  // leftmost symbol lands in the low bits
  function automatic logic [DISP_W-1:0] pack4(
    input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b,
    input logic [SYM_W-1:0] c, input logic [SYM_W-1:0] d);
    return {d, c, b, a};
  endfunction

  // true when the selected mode makes use of the given input step
  function automatic logic step_kept(input ctl_state_e s, input logic [1:0] m);
    case (s)
      ST_IN_FV:   return m == MODE_RATE;
      ST_IN_PV:   return (m == MODE_RATE) || (m == MODE_FV);
      ST_IN_RATE: return (m == MODE_FV) || (m == MODE_DT);
      ST_IN_YRS:  return (m == MODE_RATE) || (m == MODE_FV);
      default:    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/calc_operand_bank.sv
module calc_operand_bank
  import calc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              arst,
  input  logic              ld_fv,
  input  logic              ld_pv,
  input  logic              ld_rate,
  input  logic              ld_yrs,
  input  logic [1:0]        slice_sel,
  input  logic [SW_W-1:0]   sw,
  output logic [OPND_W-1:0] fv_q,
  output logic [OPND_W-1:0] pv_q,
  output logic [RATE_W-1:0] rate_q,
  output logic [YRS_W-1:0]  yrs_q
);

  localparam int LO_W = SW_W;
  localparam int HI_W = OPND_W - 2 * SW_W;

  function automatic logic [OPND_W-1:0] merge_slice(
    input logic [OPND_W-1:0] cur, input logic [1:0] sel, input logic [SW_W-1:0] s);
    logic [OPND_W-1:0] v;
    v = cur;
    case (sel)
      2'd0:    v[LO_W-1:0]         = s;
      2'd1:    v[2*LO_W-1:LO_W]    = s;
      default: v[OPND_W-1:2*LO_W]  = s[HI_W-1:0];
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      fv_q   <= '0;
      pv_q   <= '0;
      rate_q <= RATE_W'(1);
      yrs_q  <= YRS_W'(1);
    end else begin
      if (ld_fv)   fv_q   <= merge_slice(fv_q, slice_sel, sw);
      if (ld_pv)   pv_q   <= merge_slice(pv_q, slice_sel, sw);
      if (ld_rate) rate_q <= sw[RATE_W-1:0];
      if (ld_yrs)  yrs_q  <= sw[YRS_W-1:0];
    end
  end

  p_fv_hold_r6: assert property (@(posedge clk) disable iff (arst)
    !ld_fv |=> $stable(fv_q));
  p_pv_hold_r6: assert property (@(posedge clk) disable iff (arst)
    !ld_pv |=> $stable(pv_q));
  p_rate_hold_r6: assert property (@(posedge clk) disable iff (arst)
    !ld_rate |=> $stable(rate_q));
  p_load_onehot_r6: assert property (@(posedge clk) disable iff (arst)
    $onehot0({ld_fv, ld_pv, ld_rate, ld_yrs}));

endmodule

// File: rtl/calc_echo_timer.sv
module calc_echo_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic arst,
  input  logic arm,
  output logic first,
  output logic expired
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)             cnt <= '0;
    else if (arm)         cnt <= TOP;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign first   = (cnt == TOP);
  assign expired = (cnt == '0);

  p_arm_top_r7: assert property (@(posedge clk) disable iff (arst)
    arm |=> first);
  p_drain_r7: assert property (@(posedge clk) disable iff (arst)
    (!arm && expired) |=> expired);

endmodule

// File: rtl/calc_disp_sel.sv
module calc_disp_sel
  import calc_entry_pkg::*;
(
  input  ctl_state_e        state,
  input  logic              err_in,
  input  logic [DISP_W-1:0] dig_in,
  input  logic [RATE_W-1:0] rate_q,
  input  logic [YRS_W-1:0]  yrs_q,
  output logic [DISP_W-1:0] disp
);

  logic [DISP_W-1:0] prompt;

  always_comb begin
    case (state)
      ST_IN_FV:   prompt = pack4(7'd8, SYM_DASH, 7'd15, 7'd30);
      ST_IN_PV:   prompt = pack4(7'd7, SYM_DASH, 7'd25, 7'd30);
      ST_IN_RATE: prompt = pack4(7'd6, SYM_DASH, 7'd1,  7'd22);
      default:    prompt = pack4(7'd5, SYM_DASH, 7'd34, 7'd29);
    endcase
  end

  always_comb begin
    case (state)
      ST_RST, ST_READY:
        disp = pack4(7'd22, 7'd0, 7'd13, 7'd14);
      ST_IN_FV, ST_IN_PV, ST_IN_RATE, ST_IN_YRS:
        disp = err_in ? dig_in : prompt;
      ST_ECHO_RATE:
        disp = pack4(7'd1, 7'd22, SYM_EQ, rate_q);
      ST_ECHO_YRS:
        disp = pack4(7'd34, 7'd29, SYM_EQ, {1'b0, yrs_q});
      default:
        disp = dig_in;
    endcase
  end

endmodule

// File: rtl/calc_entry_ctrl.sv
module calc_entry_ctrl
  import calc_entry_pkg::*;
#(
  parameter int ECHO_CYCLES = 1000
) (
  input  logic              clk,
  input  logic [SW_W-1:0]   sw,
  input  logic [3:0]        key,
  input  logic              err_in,
  input  logic [DISP_W-1:0] dig_in,
  output logic [DISP_W-1:0] disp_out,
  output logic [OPND_W-1:0] fv_out,
  output logic [OPND_W-1:0] pv_out,
  output logic [RATE_W-1:0] rate_out,
  output logic [YRS_W-1:0]  years_out,
  output logic [1:0]        mode_out,
  output logic              start_rate,
  output logic              start_fv,
  output logic              start_dt,
  output logic              conv_start,
  output logic              sys_rst,
  output logic [2:0]        led_mode,
  output logic              led_done
);

  logic       arst;
  ctl_state_e state, nxt;
  logic [1:0] mode;
  logic       ld_fv, ld_pv, ld_rate, ld_yrs, arm;
  logic       any_ld, kept;
  logic [1:0] slice_sel;
  logic       echo_first, echo_expired;

  assign arst      = (&key) & ~sw[9];
  assign any_ld    = key[0] | key[1] | key[2];
  assign slice_sel = key[0] ? 2'd0 : (key[1] ? 2'd1 : 2'd2);
  assign kept      = step_kept(state, mode);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      state <= ST_RST;
      mode  <= MODE_NONE;
    end else begin
      state <= nxt;
      if (state == ST_READY && key[0]) mode <= sw[1:0];
    end
  end

  always_comb begin
    nxt     = state;
    ld_fv   = 1'b0;
    ld_pv   = 1'b0;
    ld_rate = 1'b0;
    ld_yrs  = 1'b0;
    arm     = 1'b0;
    case (state)
      ST_RST:   nxt = ST_READY;
      ST_READY: if (key[3] && sw[9]) nxt = ST_IN_FV;
      ST_IN_FV: begin
        if (!kept) nxt = ST_IN_PV;
        else if (any_ld) begin ld_fv = 1'b1; arm = 1'b1; nxt = ST_ECHO_FV; end
        else if (key[3] && sw[8]) nxt = ST_IN_PV;
      end
      ST_IN_PV: begin
        if (!kept) nxt = ST_IN_RATE;
        else if (any_ld) begin ld_pv = 1'b1; arm = 1'b1; nxt = ST_ECHO_PV; end
        else if (key[3] && sw[7]) nxt = ST_IN_RATE;
      end
      ST_IN_RATE: begin
        if (!kept) nxt = ST_IN_YRS;
        else if (key[0]) begin ld_rate = 1'b1; arm = 1'b1; nxt = ST_ECHO_RATE; end
        else if (key[3] && sw[6]) nxt = ST_IN_YRS;
      end
      ST_IN_YRS: begin
        if (!kept) nxt = ST_LAUNCH0;
        else if (key[0]) begin ld_yrs = 1'b1; arm = 1'b1; nxt = ST_ECHO_YRS; end
        else if (key[3] && sw[5]) nxt = ST_LAUNCH0;
      end
      ST_ECHO_FV:   if (echo_expired) nxt = ST_IN_FV;
      ST_ECHO_PV:   if (echo_expired) nxt = ST_IN_PV;
      ST_ECHO_RATE: if (echo_expired) nxt = ST_IN_RATE;
      ST_ECHO_YRS:  if (echo_expired) nxt = ST_IN_YRS;
      ST_LAUNCH0:   nxt = (mode == MODE_NONE) ? ST_READY : ST_LAUNCH1;
      ST_LAUNCH1:   nxt = ST_RESULT;
      default:      nxt = ST_RESULT;
    endcase
  end

  calc_operand_bank u_bank (
    .clk(clk), .arst(arst),
    .ld_fv(ld_fv), .ld_pv(ld_pv), .ld_rate(ld_rate), .ld_yrs(ld_yrs),
    .slice_sel(slice_sel), .sw(sw),
    .fv_q(fv_out), .pv_q(pv_out), .rate_q(rate_out), .yrs_q(years_out)
  );

  calc_echo_timer #(.CYCLES(ECHO_CYCLES)) u_timer (
    .clk(clk), .arst(arst), .arm(arm),
    .first(echo_first), .expired(echo_expired)
  );

  calc_disp_sel u_disp (
    .state(state), .err_in(err_in), .dig_in(dig_in),
    .rate_q(rate_out), .yrs_q(years_out), .disp(disp_out)
  );

  logic launch_lo;
  assign launch_lo  = (state == ST_LAUNCH0);
  assign start_rate = !(launch_lo && mode == MODE_RATE);
  assign start_fv   = !(launch_lo && mode == MODE_FV);
  assign start_dt   = !(launch_lo && mode == MODE_DT);
  assign conv_start = !(((state == ST_ECHO_FV) || (state == ST_ECHO_PV)) && echo_first);
  assign sys_rst    = (state == ST_RST);
  assign mode_out   = mode;
  assign led_done   = (state == ST_RESULT);

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_led
      assign led_mode[g] = (mode == 2'(g));
    end
  endgenerate

  p_rst_release_r1: assert property (@(posedge clk) disable iff (arst)
    sys_rst |=> !sys_rst);
  p_led_onehot_r3: assert property (@(posedge clk) disable iff (arst)
    $onehot0(led_mode));
  p_one_start_r10: assert property (@(posedge clk) disable iff (arst)
    $countones({start_rate, start_fv, start_dt}) >= 2);
  p_start_rise_r10: assert property (@(posedge clk) disable iff (arst)
    !(start_rate && start_fv && start_dt) |=> (start_rate && start_fv && start_dt && !led_done));
  p_done_sticky_r11: assert property (@(posedge clk) disable iff (arst)
    led_done |=> led_done);
  p_conv_pulse_r7: assert property (@(posedge clk) disable iff (arst)
    !conv_start |=> conv_start);
  p_echo_back_r7: assert property (@(posedge clk) disable iff (arst)
    (state == ST_ECHO_RATE && echo_expired) |=> state == ST_IN_RATE);
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (arst)
    (state != ST_READY) |=> $stable(mode_out));

endmodule

// File: tb/calc_entry_ctrl_test.sv
module calc_entry_ctrl_test;

  localparam int ECHO = 4;

  logic        clk = 1'b0;
  logic [9:0]  sw = '0;
  logic [3:0]  key = '0;
  logic        err_in = 1'b0;
  logic [27:0] dig_in = '0;
  logic [27:0] disp_out;
  logic [26:0] fv_out, pv_out;
  logic [6:0]  rate_out;
  logic [5:0]  years_out;
  logic [1:0]  mode_out;
  logic        start_rate, start_fv, start_dt, conv_start, sys_rst, led_done;
  logic [2:0]  led_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 0;

  calc_entry_ctrl #(.ECHO_CYCLES(ECHO)) uut (
    .clk(clk), .sw(sw), .key(key), .err_in(err_in), .dig_in(dig_in),
    .disp_out(disp_out), .fv_out(fv_out), .pv_out(pv_out),
    .rate_out(rate_out), .years_out(years_out), .mode_out(mode_out),
    .start_rate(start_rate), .start_fv(start_fv), .start_dt(start_dt),
    .conv_start(conv_start), .sys_rst(sys_rst), .led_mode(led_mode),
    .led_done(led_done)
  );

  always #4 clk = ~clk;

  task automatic report;
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] sym4(input int a, input int b, input int c, input int d);
    return {7'(d), 7'(c), 7'(b), 7'(a)};
  endfunction

  function automatic bit kept(input int j, input int m);
    case (j)
      0: return m == 0;
      1: return m <= 1;
      2: return (m == 1) || (m == 2);
      default: return m <= 1;
    endcase
  endfunction

  function automatic logic [27:0] prompt(input int j);
    case (j)
      0: return sym4(8, 37, 15, 30);
      1: return sym4(7, 37, 25, 30);
      2: return sym4(6, 37, 1, 22);
      default: return sym4(5, 37, 34, 29);
    endcase
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic press(input logic [3:0] k, input logic [9:0] s);
    @(negedge clk);
    key = k; sw = s;
    @(negedge clk);
    key = '0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    key = 4'hF; sw = '0;
    #1;
    chk("R1 fv", 32'(fv_out), 0);
    chk("R1 pv", 32'(pv_out), 0);
    chk("R1 rate", 32'(rate_out), 1);
    chk("R1 years", 32'(years_out), 1);
    chk("R1 mode", 32'(mode_out), 3);
    chk("R1 sys_rst", 32'(sys_rst), 1);
    @(negedge clk);
    key = '0;
    tick();
    chk("R1 sys_rst released", 32'(sys_rst), 0);
    chk("R2 ready display", 32'(disp_out), 32'(sym4(22, 0, 13, 14)));
  endtask

  // money step: three slice loads plus a two-button load
  task automatic money_step(input int j, inout logic [26:0] model);
    logic [9:0] d;
    for (int s = 0; s < 4; s++) begin
      d = 10'(10'h2A5 ^ (s * 10'h0C3) ^ (j * 10'h111));
      if (s < 3) begin
        press(4'(1 << s), d);
        case (s)
          0: model[9:0] = d;
          1: model[19:10] = d;
          default: model[26:20] = d[6:0];
        endcase
      end else begin
        press(4'b0110, d);
        model[19:10] = d;
      end
      chk("R8 money echo shows digits", 32'(disp_out), 32'(dig_in));
      chk("R7 conv_start low first echo cycle", 32'(conv_start), 0);
      tick();
      chk("R7 conv_start high after", 32'(conv_start), 1);
      repeat (ECHO - 2) tick();
      chk("R7 echo still active at last cycle", 32'(disp_out), 32'(dig_in));
      tick();
      chk("R7 echo returns to prompt", 32'(disp_out), 32'(prompt(j)));
    end
    chk("R6 money operand", 32'(j == 0 ? fv_out : pv_out), 32'(model));
  endtask

  task automatic small_step(input int j);
    int lim;
    lim = (j == 2) ? 128 : 64;
    for (int v = 0; v < lim; v++) begin
      press(4'b0001, 10'(v) | 10'h380);
      if (j == 2)
        chk("R8 rate echo", 32'(disp_out), 32'(sym4(1, 22, 36, v)));
      else
        chk("R8 years echo", 32'(disp_out), 32'(sym4(34, 29, 36, v)));
      chk("R7 conv_start idle in small echo", 32'(conv_start), 1);
      repeat (ECHO) tick();
      chk("R7 small echo returns", 32'(disp_out), 32'(prompt(j)));
      chk("R6 small operand", 32'(j == 2 ? 32'(rate_out) : 32'(years_out)), 32'(v));
    end
    press(4'b0110, 10'h3FF);
    chk("R6 buttons 1,2 ignored display", 32'(disp_out), 32'(prompt(j)));
    chk("R6 buttons 1,2 ignored value", 32'(j == 2 ? 32'(rate_out) : 32'(years_out)), 32'(lim - 1));
  endtask

  task automatic run_mode(input int m);
    int j;
    logic [26:0] fvm, pvm;
    fvm = '0; pvm = '0;
    do_reset();
    dig_in = 28'h5A3C1E7 ^ 28'(m * 28'h1111111);
    press(4'b0001, 10'(m));
    chk("R2 mode load", 32'(mode_out), 32'(m));
    chk("R3 mode leds", 32'(led_mode), (m == 3) ? 0 : 32'(1 << m));
    press(4'b1000, 10'h100);
    chk("R4 wrong switch in ready", 32'(disp_out), 32'(sym4(22, 0, 13, 14)));
    press(4'b1000, 10'h200);
    j = 0;
    while (j < 4) begin
      if (!kept(j, m)) begin
        tick();
        j++;
        continue;
      end
      chk("R9 prompt", 32'(disp_out), 32'(prompt(j)));
      err_in = 1'b1;
      #1;
      chk("R9 error shows digits", 32'(disp_out), 32'(dig_in));
      err_in = 1'b0;
      press(4'b1000, 10'h010);
      chk("R4 wrong advance switch", 32'(disp_out), 32'(prompt(j)));
      if (j == 0) money_step(0, fvm);
      else if (j == 1) money_step(1, pvm);
      else small_step(j);
      press(4'b1001, 10'(1 << (8 - j)) | 10'h003);
      chk("R6 load beats advance", 32'(disp_out == prompt(j)), 0);
      repeat (ECHO) tick();
      press(4'b1000, 10'(1 << (8 - j)));
      j++;
    end
    // now in first launch cycle
    chk("R10 start lines", 32'({start_dt, start_fv, start_rate}),
        (m == 3) ? 7 : 32'(3'b111 & ~3'(1 << m)));
    chk("R5 fv untouched when skipped", 32'(fv_out), (m == 0) ? 32'(fv_out) : 0);
    tick();
    if (m == 3) begin
      chk("R10 mode 11 returns to ready", 32'(disp_out), 32'(sym4(22, 0, 13, 14)));
      chk("R11 no result", 32'(led_done), 0);
    end else begin
      chk("R10 second launch all high", 32'({start_dt, start_fv, start_rate}), 7);
      chk("R11 not done yet", 32'(led_done), 0);
      tick();
      chk("R11 result led", 32'(led_done), 1);
      chk("R11 result display", 32'(disp_out), 32'(dig_in));
      press(4'b1001, 10'h3E3);
      chk("R11 result sticky", 32'(led_done), 1);
      chk("R11 mode held", 32'(mode_out), 32'(m));
      chk("R11 starts idle", 32'({start_dt, start_fv, start_rate}), 7);
    end
  endtask

  initial begin
    tick();
    for (int m = 0; m < 4; m++) run_mode(m);
    do_reset();
    report();
    $finish;
  end

endmodule